// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block behaves as a byte-addressed memory on a two-wire serial bus. It runs on a fast system clock, oversamples the already-synchronized clock and data lines, and pulls the data line low through an open-drain enable when it acknowledges or sends a zero bit. Three strap inputs set its bus address, so several copies can share one bus.

A host writes by sending the device byte, two word-address bytes and one or more data bytes, then a stop. Data bytes collect in a page-sized buffer and go into the storage array only after the stop. A timed busy period follows, during which the target ignores the bus, so the host can poll for an acknowledge to learn when the write has finished. Reads return data from an internal address pointer. The host can load that pointer first with an address-only write and a repeated start, and can keep reading for as long as it acknowledges each byte. A write-protect input keeps the array unchanged.

Top module: `serial_mem_target`

## Requirements
- R1: A start (data falling while clock is high) begins reception of a device byte, from any state except busy. After a stop (data rising while clock is high) the target acknowledges nothing until the next start.
- R2: The device byte is sent MSB first as 1,0,1,0, strap[2], strap[1], strap[0], then the read/write bit (1 = read). Acknowledge means the target holds data low for the whole ninth clock-high phase. On a device byte whose upper seven bits differ, the target gives no acknowledge and ignores every later bit until the next start.
- R3: Incoming bits are taken on the clock rising edge. The target changes its data-line drive only while the clock is low.
- R4: A write carries a high and a low word-address byte after the device byte. Only the low log2(MEM_BYTES) address bits count. Every byte is acknowledged, and after the stop and the busy period a single data byte reads back at the truncated address.
- R5: In a multi-byte write only the low log2(PAGE_BYTES) address bits advance, wrapping within the page. Bytes past the page size overwrite earlier bytes of the same page, and neighbouring pages stay unchanged.
- R6: A stop after at least one data byte starts a busy period of WRITE_CYCLES system clocks. During that period a device byte gets no acknowledge; once it ends, a device byte is acknowledged again.
- R7: A read with no preceding address load returns the byte one past the last byte accessed, wrapping from the top of the array to 0.
- R8: An address-only write followed by a repeated start and a read device byte returns the byte at the loaded address.
- R9: While the host acknowledges each byte, the read continues at the next address, rolling from the last array byte to byte 0.
- R10: While write-protect is high, the target still acknowledges the device, address and data bytes, but the array does not change and no busy period starts.
- R11: After the host leaves a read byte unacknowledged, the target stops driving the data line and sends no more data.
- R12: After reset the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized serial clock line |
| sdaIn | input | 1 | Synchronized serial data line level |
| strapAddr | input | 3 | Bus address straps |
| wrProtect | input | 1 | High blocks all array updates |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
A wrong bit counter or state appears at the ports within one byte: the acknowledge moves off the ninth clock, or a byte that should be refused is acknowledged. Faults in the page offset or the drain of the buffer stay hidden until a read after the busy period, which then returns a wrong byte or changes a byte in a neighbouring page. A busy counter that is off shows up on the next address probe, which is acknowledged too early or refused too late. A pointer that does not wrap shows up one byte after the top of the array in a sequential read.

// File: rtl/smt_pkg.sv
package smt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT, ST_BUSY
  } busState_t;

  // strobes from protocol control to the storage datapath
  typedef struct packed {
    logic       setHi;   // high word-address byte received
    logic       setLo;   // low word-address byte received
    logic       wrByte;  // write data byte received
    logic       commit;  // stop after write data: drain page buffer
    logic       incRd;   // one read byte sent
    logic [7:0] byteVal;
  } ctrlStrobe_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/smt_ctrl.sv
module smt_ctrl
  import smt_pkg::*;
#(
  parameter int WRITE_CYCLES = 400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strapAddr,
  input  logic        wrProtect,
  input  logic [7:0]  rdData,
  output ctrlStrobe_t strobes,
  output logic        sdaLow
);
  localparam int CW = $clog2(WRITE_CYCLES);

  busState_t      state;
  logic           sclQ, sdaQ;
  logic [3:0]     bitCnt;
  logic           ackPhase, hostAck, dataSeen;
  logic [7:0]     rxShift;
  logic [6:0]     txShift;
  logic [CW-1:0]  busyCnt;
  logic           sdaLowQ;

  logic sclRise, sclFall, startSeen, stopSeen, byteDone, addrHit;

  assign sclRise   = !sclQ && sclIn;
  assign sclFall   = sclQ && !sclIn;
  assign startSeen = sclQ && sclIn && sdaQ && !sdaIn;
  assign stopSeen  = sclQ && sclIn && !sdaQ && sdaIn;
  assign byteDone  = sclFall && !ackPhase && (bitCnt == 4'd8);
  assign addrHit   = (rxShift[7:1] == {DEV_TYPE, strapAddr});
  assign sdaLow    = sdaLowQ;

  always_comb begin
    strobes = '0;
    strobes.byteVal = rxShift;
    strobes.commit  = stopSeen && (state == ST_WDAT) && dataSeen && !wrProtect;
    if (byteDone) begin
      case (state)
        ST_AHI:  strobes.setHi  = 1'b1;
        ST_ALO:  strobes.setLo  = 1'b1;
        ST_WDAT: strobes.wrByte = 1'b1;
        ST_RDAT: strobes.incRd  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      hostAck  <= 1'b0;
      dataSeen <= 1'b0;
      rxShift  <= '0;
      txShift  <= '0;
      busyCnt  <= '0;
      sdaLowQ  <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (state == ST_BUSY) begin
        sdaLowQ <= 1'b0;
        if (busyCnt == CW'(WRITE_CYCLES - 1)) begin
          state   <= ST_IDLE;
          busyCnt <= '0;
        end else begin
          busyCnt <= busyCnt + 1'b1;
        end
      end else if (startSeen) begin
        state    <= ST_DEV;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        dataSeen <= 1'b0;
        sdaLowQ  <= 1'b0;
      end else if (stopSeen) begin
        state    <= strobes.commit ? ST_BUSY : ST_IDLE;
        busyCnt  <= '0;
        ackPhase <= 1'b0;
        sdaLowQ  <= 1'b0;
      end else if (state == ST_RDAT) begin
        if (sclRise) begin
          if (ackPhase) hostAck <= !sdaIn;
          else          bitCnt  <= bitCnt + 4'd1;
        end else if (sclFall) begin
          if (ackPhase) begin
            ackPhase <= 1'b0;
            if (hostAck) begin
              bitCnt  <= '0;
              txShift <= rdData[6:0];
              sdaLowQ <= !rdData[7];
            end else begin
              state   <= ST_IDLE;
              sdaLowQ <= 1'b0;
            end
          end else if (bitCnt == 4'd8) begin
            ackPhase <= 1'b1;
            sdaLowQ  <= 1'b0;
          end else begin
            sdaLowQ <= !txShift[6];
            txShift <= {txShift[5:0], 1'b0};
          end
        end
      end else if (state != ST_IDLE) begin
        if (sclRise && !ackPhase) begin
          rxShift <= {rxShift[6:0], sdaIn};
          bitCnt  <= bitCnt + 4'd1;
        end else if (sclFall) begin
          if (ackPhase) begin
            ackPhase <= 1'b0;
            bitCnt   <= '0;
            sdaLowQ  <= 1'b0;
            if (state == ST_DEV && rxShift[0]) begin
              state   <= ST_RDAT;
              txShift <= rdData[6:0];
              sdaLowQ <= !rdData[7];
            end else if (state == ST_DEV) begin
              state <= ST_AHI;
            end else if (state == ST_AHI) begin
              state <= ST_ALO;
            end else begin
              state <= ST_WDAT;
            end
          end else if (bitCnt == 4'd8) begin
            if (state == ST_DEV && !addrHit) begin
              state <= ST_IDLE;
            end else begin
              ackPhase <= 1'b1;
              sdaLowQ  <= 1'b1;
              if (state == ST_WDAT) dataSeen <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R6: nothing is driven while the write cycle runs
  assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> !sdaLowQ);

  // R6: the busy period lasts exactly WRITE_CYCLES clocks
  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_BUSY) |-> ($past(busyCnt) == CW'(WRITE_CYCLES - 1)));

  // R3: the data-line drive only moves while the clock is low
  assert_drive_on_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLowQ != $past(sdaLowQ)) |-> !$past(sclIn));

  // R10: a write cycle never starts under write protection
  assert_protect_no_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_BUSY) |-> $past(!wrProtect));
endmodule

// File: rtl/smt_data.sv
module smt_data
  import smt_pkg::*;
#(
  parameter int MEM_BYTES  = 1024,
  parameter int PAGE_BYTES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobes,
  output logic [7:0]  rdData
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;

  logic [7:0]            memArr  [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [ADDR_W-1:0]     addrPtr;
  logic [HI_W-1:0]       hiBits;
  logic                  draining;
  logic [OFF_W-1:0]      drainIdx;

  assign rdData = memArr[addrPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPtr   <= '0;
      hiBits    <= '0;
      pageValid <= '0;
      draining  <= 1'b0;
      drainIdx  <= '0;
    end else begin
      if (strobes.setHi) hiBits <= strobes.byteVal[HI_W-1:0];
      if (strobes.setLo) begin
        addrPtr   <= {hiBits, strobes.byteVal};
        pageValid <= '0;
      end
      if (strobes.wrByte) begin
        pageValid[addrPtr[OFF_W-1:0]] <= 1'b1;
        addrPtr <= {addrPtr[ADDR_W-1:OFF_W], addrPtr[OFF_W-1:0] + 1'b1};
      end
      if (strobes.incRd) addrPtr <= addrPtr + 1'b1;
      if (strobes.commit) begin
        draining <= 1'b1;
        drainIdx <= '0;
      end else if (draining) begin
        drainIdx <= drainIdx + 1'b1;
        if (drainIdx == OFF_W'(PAGE_BYTES - 1)) begin
          draining  <= 1'b0;
          pageValid <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrByte) pageBuf[addrPtr[OFF_W-1:0]] <= strobes.byteVal;
    if (draining && pageValid[drainIdx])
      memArr[{addrPtr[ADDR_W-1:OFF_W], drainIdx}] <= pageBuf[drainIdx];
  end

  // R5: a data byte never moves the pointer out of its page
  assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrByte |=> (addrPtr[ADDR_W-1:OFF_W] == $past(addrPtr[ADDR_W-1:OFF_W])));

  // R4: control never issues two datapath actions in one cycle
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.setHi, strobes.setLo, strobes.wrByte, strobes.commit, strobes.incRd}));
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
  import smt_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       wrProtect,
  output logic       sdaDriveLow
);
  ctrlStrobe_t strobes;
  logic [7:0]  rdData;

  smt_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapAddr(strapAddr), .wrProtect(wrProtect), .rdData(rdData),
    .strobes(strobes), .sdaLow(sdaDriveLow)
  );

  smt_data #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdData(rdData)
  );
endmodule

// File: tb/serial_mem_target_bench.sv
module serial_mem_target_bench;
  localparam int WC = 200;
  localparam int Q  = 4;
  localparam logic [15:0] AMASK = 16'h03FF;
  localparam logic [23:0] VEC [5] = '{
    {16'h003F, 8'h5A}, {16'h0060, 8'hC3}, {16'h03FF, 8'h81},
    {16'h0000, 8'h7E}, {16'h0C01, 8'h12}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hostLow = 1'b0;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic dutLow;
  logic sdaLine;
  assign sdaLine = !(hostLow || dutLow);

  int checks = 0;
  int fails = 0;
  int r3Bad = 0;
  logic ack;
  logic [7:0] rd;

  always #4 clk = !clk;

  serial_mem_target #(.WRITE_CYCLES(WC)) u_serial_mem_target (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .strapAddr(strap), .wrProtect(wp), .sdaDriveLow(dutLow)
  );

  // R3 monitor: drive may change only while the clock line is low
  logic prevLow = 1'b0;
  always @(negedge clk) begin
    if (rstN && dutLow != prevLow && scl) r3Bad++;
    prevLow <= dutLow;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startCond();
    hostLow = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    hostLow = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    scl = 1'b0; hostLow = 1'b1; tick(Q);
    scl = 1'b1; tick(Q); hostLow = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic gotAck);
    for (int i = 7; i >= 0; i--) begin
      hostLow = !b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    end
    hostLow = 1'b0; tick(Q); scl = 1'b1; tick(Q / 2);
    gotAck = !sdaLine; tick(Q / 2); scl = 1'b0; tick(Q);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q / 2); b[i] = sdaLine; tick(Q / 2); scl = 1'b0;
    end
    tick(1); hostLow = giveAck; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
    tick(1); hostLow = 1'b0;
  endtask

  function automatic logic [7:0] devByte(input logic rw);
    return {4'b1010, strap, rw};
  endfunction

  task automatic byteWrite(input logic [15:0] a, input logic [7:0] d, input string req);
    logic k;
    startCond();
    sendByte(devByte(1'b0), k); check(req, k, 1);
    sendByte(a[15:8], k);       check(req, k, 1);
    sendByte(a[7:0], k);        check(req, k, 1);
    sendByte(d, k);             check(req, k, 1);
    stopCond();
  endtask

  task automatic probe(output logic k);
    startCond(); sendByte(devByte(1'b0), k); stopCond();
  endtask

  task automatic loadAddr(input logic [15:0] a);
    logic k;
    startCond();
    sendByte(devByte(1'b0), k); check("R8", k, 1);
    sendByte(a[15:8], k);       check("R8", k, 1);
    sendByte(a[7:0], k);        check("R8", k, 1);
    startCond();
    sendByte(devByte(1'b1), k); check("R8", k, 1);
  endtask

  task automatic randomRead(input logic [15:0] a, output logic [7:0] d);
    loadAddr(a); readByte(1'b0, d); stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(5); rstN = 1'b1; tick(3);
    check("R12", dutLow, 0);

    // R2: wrong strap bits are refused, later bits ignored
    startCond();
    sendByte(8'hA0, ack); check("R2", ack, 0);
    sendByte(8'hAA, ack); check("R2", ack, 0);
    stopCond();

    // table walk: byte write, busy polling, read back
    for (int v = 0; v < 5; v++) begin
      byteWrite(VEC[v][23:8], VEC[v][7:0], "R4");
      probe(ack); check("R6", ack, 0);
      tick(WC + 40);
      probe(ack); check("R6", ack, 1);
      randomRead(VEC[v][23:8] & AMASK, rd); check("R4", rd, VEC[v][7:0]);
    end

    // R8 then R7: current read after top byte wraps to 0
    randomRead(16'h03FF, rd); check("R8", rd, 8'h81);
    startCond(); sendByte(devByte(1'b1), ack); check("R7", ack, 1);
    readByte(1'b0, rd); stopCond(); check("R7", rd, 8'h7E);

    // R9 rollover, R11 release after host NACK
    loadAddr(16'h03FF);
    readByte(1'b1, rd); check("R9", rd, 8'h81);
    readByte(1'b1, rd); check("R9", rd, 8'h7E);
    readByte(1'b0, rd); check("R9", rd, 8'h12);
    tick(Q); check("R11", dutLow, 0);
    readByte(1'b0, rd); check("R11", rd, 8'hFF);
    stopCond();

    // R5: 34 bytes into page 0x040, wraps onto offsets 0 and 1
    startCond();
    sendByte(devByte(1'b0), ack); check("R5", ack, 1);
    sendByte(8'h00, ack); check("R5", ack, 1);
    sendByte(8'h40, ack); check("R5", ack, 1);
    for (int i = 0; i < 34; i++) begin
      sendByte(8'(8'h80 + i), ack); check("R5", ack, 1);
    end
    stopCond(); tick(WC + 40);
    loadAddr(16'h003F);
    for (int i = 0; i < 34; i++) begin
      logic [7:0] exp;
      if (i == 0) exp = 8'h5A;
      else if (i == 33) exp = 8'hC3;
      else if (i <= 2) exp = 8'(8'h80 + 32 + i - 1);
      else exp = 8'(8'h80 + i - 1);
      readByte(i != 33, rd); check("R5", rd, exp);
    end
    stopCond();

    // R10: protected write is acknowledged, changes nothing, no busy
    wp = 1'b1;
    byteWrite(16'h003F, 8'hEE, "R10");
    probe(ack); check("R10", ack, 1);
    wp = 1'b0;
    randomRead(16'h003F, rd); check("R10", rd, 8'h5A);

    // R1: after a stop, bits without a start are not acknowledged
    startCond();
    sendByte(devByte(1'b0), ack); check("R1", ack, 1);
    sendByte(8'h00, ack); check("R1", ack, 1);
    stopCond();
    sendByte(devByte(1'b0), ack); check("R1", ack, 0);
    stopCond();

    check("R3", 16'(r3Bad), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule